// File: doc/BRIEF.md
# Transmit Descriptor Ring with Buffer Release

This block is the transmit queue of one switch port. A forwarding stage posts descriptors into a circular ring of 16 entries. Each descriptor carries a packet's byte count and the index of the receive buffer block that holds the packet. Each post lands at the write pointer, and that pointer then moves on by one.

Whenever the two pointers differ, the descriptor at the read pointer is offered to a transmit engine through a valid/ready handshake. Once the engine accepts it, that descriptor is in flight, and no other descriptor is offered until the engine reports that the packet is done. On that report the read pointer advances. The block also emits a one-cycle strobe carrying the buffer index, so that a shared buffer-occupancy bitmap can clear the bit of the released block.

A post into a full ring is refused and raises a sticky overflow flag. A post in the same cycle as a retire is always taken, even when the ring is full.

Top module: `tx_desc_ring`

## Requirements
- R1: While `rstN` is low, and on the first sample after it, `txValid`, `freeValid` and `overflowFlag` are 0 and `fillLevel` is 0.
- R2: An accepted post raises `fillLevel` by one after the clock edge. Descriptors are offered on `txByteCount`/`txBufIdx` in the order they were posted, with the byte count and buffer index exactly as posted.
- R3: `txValid` is 1 exactly when the ring holds at least one descriptor and no descriptor is in flight.
- R4: A cycle with `txValid` and `txReady` both high puts the head descriptor in flight, and `txValid` stays 0 until that packet is retired. A `txDone` with nothing in flight is ignored: `fillLevel` does not change and no `freeValid` strobe follows.
- R5: `txDone` while a descriptor is in flight retires it. In the next cycle `freeValid` is 1 for exactly one cycle, `freeIdx` equals that descriptor's buffer index, and `fillLevel` is one lower unless a post was accepted at the same edge.
- R6: The ring holds at most 16 descriptors. A post while 16 are held and no retire occurs is refused: `fillLevel` stays 16, `overflowFlag` goes to 1 and stays 1 until reset.
- R7: A post and a retire at the same edge are both accepted and `fillLevel` is unchanged. This holds at 16 entries too, where the post does not set `overflowFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| postValid | input | 1 | Post a descriptor this cycle |
| postByteCount | input | 12 | Packet byte count of the posted descriptor |
| postBufIdx | input | 8 | Receive buffer block index of the posted descriptor |
| txValid | output | 1 | Head descriptor offered to the transmit engine |
| txReady | input | 1 | Transmit engine takes the offered descriptor |
| txByteCount | output | 12 | Byte count of the offered descriptor |
| txBufIdx | output | 8 | Buffer index of the offered descriptor |
| txDone | input | 1 | End of transmission of the in-flight packet |
| freeValid | output | 1 | One-cycle strobe: clear the bitmap bit of `freeIdx` |
| freeIdx | output | 8 | Buffer block index being released |
| fillLevel | output | 5 | Number of descriptors held, including the one in flight |
| overflowFlag | output | 1 | Sticky: a post was refused because the ring was full |

## Verification
The assertions check on every cycle that the occupancy never exceeds 16 and moves by at most one per edge, and that a release strobe never lasts two cycles and always comes with a drop in occupancy when no post coincides. They also check that an accepted handshake withdraws `txValid`, that the overflow flag never falls, and that it rises only after a post made at full occupancy. The bench scenarios alone show the values: FIFO order of byte counts and buffer indices, the index carried by each release strobe, the ignored stray `txDone`, and post-with-retire at a full ring.

// File: rtl/tx_desc_pkg.sv
package tx_desc_pkg;
  // Strobes from the ring control to the descriptor datapath
  typedef struct packed {
    logic wrEn;   // store the posted descriptor at wrIdx
    logic rdAdv;  // retire the descriptor at rdIdx and release its buffer
    logic launch; // head descriptor handed to the transmit engine
  } ringStrobes_t;
endpackage

// File: rtl/tx_desc_ctrl.sv
module tx_desc_ctrl
  import tx_desc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          postValid,
  input  logic          txReady,
  input  logic          txDone,
  output ringStrobes_t  strobes,
  output logic [AW-1:0] wrIdx,
  output logic [AW-1:0] rdIdx,
  output logic          txValid,
  output logic [PW-1:0] fillLevel,
  output logic          overflowFlag
);
  logic [PW-1:0] wrPtr, rdPtr;
  logic          inFlight;
  logic          ringEmpty, ringFull;
  logic          retire, accept, launch;

  // Pointers carry one extra wrap bit so that full and empty differ
  assign ringEmpty = (wrPtr == rdPtr);
  assign ringFull  = (wrPtr[AW] != rdPtr[AW]) && (wrPtr[AW-1:0] == rdPtr[AW-1:0]);

  assign txValid = !ringEmpty && !inFlight;
  assign launch  = txValid && txReady;
  assign retire  = inFlight && txDone;
  // A retire in the same cycle frees the slot the post needs
  assign accept  = postValid && (!ringFull || retire);

  assign strobes.wrEn   = accept;
  assign strobes.rdAdv  = retire;
  assign strobes.launch = launch;

  assign wrIdx     = wrPtr[AW-1:0];
  assign rdIdx     = rdPtr[AW-1:0];
  assign fillLevel = wrPtr - rdPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      inFlight     <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      if (accept) wrPtr <= wrPtr + PW'(1);
      if (retire) rdPtr <= rdPtr + PW'(1);
      if (launch)      inFlight <= 1'b1;
      else if (retire) inFlight <= 1'b0;
      if (postValid && !accept) overflowFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/tx_desc_data.sv
module tx_desc_data
  import tx_desc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 12,
  parameter int IDX_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ringStrobes_t     strobes,
  input  logic [AW-1:0]    wrIdx,
  input  logic [AW-1:0]    rdIdx,
  input  logic [CNT_W-1:0] postByteCount,
  input  logic [IDX_W-1:0] postBufIdx,
  output logic [CNT_W-1:0] txByteCount,
  output logic [IDX_W-1:0] txBufIdx,
  output logic             freeValid,
  output logic [IDX_W-1:0] freeIdx
);
  logic [CNT_W-1:0] cntArr [DEPTH];
  logic [IDX_W-1:0] bufArr [DEPTH];

  // One register pair per ring slot, loaded when the write index selects it
  for (genvar slot = 0; slot < DEPTH; slot++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.wrEn && (wrIdx == AW'(slot))) begin
        cntArr[slot] <= postByteCount;
        bufArr[slot] <= postBufIdx;
      end
    end
  end

  assign txByteCount = cntArr[rdIdx];
  assign txBufIdx    = bufArr[rdIdx];

  // Release strobe: registered, one cycle per retire
  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeValid <= 1'b0;
      freeIdx   <= '0;
    end else begin
      freeValid <= strobes.rdAdv;
      if (strobes.rdAdv) freeIdx <= bufArr[rdIdx];
    end
  end
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import tx_desc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 12,
  parameter int IDX_W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int LVL_W = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             postValid,
  input  logic [CNT_W-1:0] postByteCount,
  input  logic [IDX_W-1:0] postBufIdx,
  output logic             txValid,
  input  logic             txReady,
  output logic [CNT_W-1:0] txByteCount,
  output logic [IDX_W-1:0] txBufIdx,
  input  logic             txDone,
  output logic             freeValid,
  output logic [IDX_W-1:0] freeIdx,
  output logic [LVL_W-1:0] fillLevel,
  output logic             overflowFlag
);
  ringStrobes_t  strobes;
  logic [AW-1:0] wrIdx, rdIdx;

  tx_desc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .postValid    (postValid),
    .txReady      (txReady),
    .txDone       (txDone),
    .strobes      (strobes),
    .wrIdx        (wrIdx),
    .rdIdx        (rdIdx),
    .txValid      (txValid),
    .fillLevel    (fillLevel),
    .overflowFlag (overflowFlag)
  );

  tx_desc_data #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrIdx         (wrIdx),
    .rdIdx         (rdIdx),
    .postByteCount (postByteCount),
    .postBufIdx    (postBufIdx),
    .txByteCount   (txByteCount),
    .txBufIdx      (txBufIdx),
    .freeValid     (freeValid),
    .freeIdx       (freeIdx)
  );
endmodule

// File: rtl/tx_desc_ring_chk.sv
module tx_desc_ring_chk #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 8,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             postValid,
  input logic             txValid,
  input logic             txReady,
  input logic             freeValid,
  input logic [IDX_W-1:0] freeIdx,
  input logic [LVL_W-1:0] fillLevel,
  input logic             overflowFlag
);
  // R3
  offer_needs_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (fillLevel != '0));

  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LVL_W'(DEPTH));

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillLevel == $past(fillLevel)) || (fillLevel == $past(fillLevel) + LVL_W'(1))
    || (fillLevel + LVL_W'(1) == $past(fillLevel)));

  // R4
  launch_withdraw_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txValid);

  // R5
  free_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |=> !freeValid);

  // R5
  free_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freeValid && !$past(postValid)) |-> (fillLevel + LVL_W'(1) == $past(fillLevel)));

  // R6
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R6
  overflow_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowFlag) |-> ($past(postValid) && ($past(fillLevel) == LVL_W'(DEPTH))));

  // R5
  free_idx_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    freeValid |-> !$isunknown(freeIdx));
endmodule

bind tx_desc_ring tx_desc_ring_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .postValid    (postValid),
  .txValid      (txValid),
  .txReady      (txReady),
  .freeValid    (freeValid),
  .freeIdx      (freeIdx),
  .fillLevel    (fillLevel),
  .overflowFlag (overflowFlag)
);

// File: tb/tx_desc_ring_tb.sv
`timescale 1ns/1ps
module tx_desc_ring_tb;
  localparam int DEPTH = 16;
  localparam int CNT_W = 12;
  localparam int IDX_W = 8;
  localparam int LVL_W = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             postValid = 1'b0;
  logic [CNT_W-1:0] postByteCount = '0;
  logic [IDX_W-1:0] postBufIdx = '0;
  logic             txReady = 1'b0;
  logic             txDone = 1'b0;
  logic             txValid;
  logic [CNT_W-1:0] txByteCount;
  logic [IDX_W-1:0] txBufIdx;
  logic             freeValid;
  logic [IDX_W-1:0] freeIdx;
  logic [LVL_W-1:0] fillLevel;
  logic             overflowFlag;

  int checks = 0;
  int errors = 0;

  // Bench model of the ring contents
  logic [CNT_W-1:0] qCnt[$];
  logic [IDX_W-1:0] qIdx[$];
  logic             mBusy = 1'b0;
  logic             mOvf = 1'b0;
  logic             mFreeV = 1'b0;
  logic [IDX_W-1:0] mFreeIdx = '0;

  always #2 clk = ~clk;

  tx_desc_ring u_dut (
    .clk(clk), .rstN(rstN), .postValid(postValid), .postByteCount(postByteCount),
    .postBufIdx(postBufIdx), .txValid(txValid), .txReady(txReady),
    .txByteCount(txByteCount), .txBufIdx(txBufIdx), .txDone(txDone),
    .freeValid(freeValid), .freeIdx(freeIdx), .fillLevel(fillLevel),
    .overflowFlag(overflowFlag)
  );

  function automatic logic expOffer(input int depthNow, input logic busy);
    return (depthNow != 0) && !busy;
  endfunction

  function automatic logic expAccept(input logic pv, input int depthNow, input logic ret);
    return pv && ((depthNow < DEPTH) || ret);
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareOutputs();
    logic eo;
    eo = expOffer(qCnt.size(), mBusy);
    check(fillLevel == LVL_W'(qCnt.size()), "R2 fillLevel", int'(fillLevel), qCnt.size());
    check(txValid == eo, "R3 txValid", int'(txValid), int'(eo));
    if (eo && txValid) begin
      check(txByteCount == qCnt[0], "R2 txByteCount", int'(txByteCount), int'(qCnt[0]));
      check(txBufIdx == qIdx[0], "R2 txBufIdx", int'(txBufIdx), int'(qIdx[0]));
    end
    check(freeValid == mFreeV, "R5 freeValid", int'(freeValid), int'(mFreeV));
    if (mFreeV)
      check(freeIdx == mFreeIdx, "R5 freeIdx", int'(freeIdx), int'(mFreeIdx));
    check(overflowFlag == mOvf, "R6 overflowFlag", int'(overflowFlag), int'(mOvf));
  endtask

  // One cycle: check what the last edge produced, then drive and update the model
  task automatic step(input logic pv, input logic [CNT_W-1:0] bc,
                      input logic [IDX_W-1:0] bi, input logic rdy, input logic dn);
    logic launch, retire, acc;
    @(negedge clk);
    compareOutputs();
    postValid = pv; postByteCount = bc; postBufIdx = bi; txReady = rdy; txDone = dn;
    launch = expOffer(qCnt.size(), mBusy) && rdy;
    retire = mBusy && dn;
    acc    = expAccept(pv, qCnt.size(), retire);
    mFreeV = retire;
    if (retire) begin
      mFreeIdx = qIdx[0];
      void'(qCnt.pop_front());
      void'(qIdx.pop_front());
    end
    if (acc) begin
      qCnt.push_back(bc);
      qIdx.push_back(bi);
    end
    if (pv && !acc) mOvf = 1'b1;
    if (launch) mBusy = 1'b1;
    else if (retire) mBusy = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check(txValid == 1'b0, "R1 txValid in reset", int'(txValid), 0);
    check(freeValid == 1'b0, "R1 freeValid in reset", int'(freeValid), 0);
    check(overflowFlag == 1'b0, "R1 overflow in reset", int'(overflowFlag), 0);
    check(fillLevel == '0, "R1 fillLevel in reset", int'(fillLevel), 0);
    rstN = 1'b1;

    // R4: stray done with nothing in flight
    step(1'b0, '0, '0, 1'b0, 1'b1);
    step(1'b0, '0, '0, 1'b0, 1'b1);

    // R6: fill all 16 entries with the engine stalled
    for (int k = 0; k < DEPTH; k++)
      step(1'b1, CNT_W'(64 + 37 * k), IDX_W'(200 - k), 1'b0, 1'b0);
    step(1'b0, '0, '0, 1'b1, 1'b0);          // launch head (R4)
    step(1'b0, '0, '0, 1'b0, 1'b1);          // stray-free check: in flight, done retires
    // refill to 16, relaunch, then post and retire together at full (R7)
    step(1'b1, 12'd1500, 8'd7, 1'b0, 1'b0);
    step(1'b0, '0, '0, 1'b1, 1'b0);
    @(negedge clk);
    check(fillLevel == LVL_W'(DEPTH), "R7 full before joint post", int'(fillLevel), DEPTH);
    step(1'b1, 12'd99, 8'd3, 1'b0, 1'b1);
    step(1'b0, '0, '0, 1'b0, 1'b0);
    check(fillLevel == LVL_W'(DEPTH), "R7 level after joint post", int'(fillLevel), DEPTH);
    check(overflowFlag == 1'b0, "R7 no overflow on joint post", int'(overflowFlag), 0);
    // R6: post at full with no retire is refused
    step(1'b1, 12'd555, 8'd55, 1'b0, 1'b0);
    step(1'b0, '0, '0, 1'b0, 1'b0);
    check(overflowFlag == 1'b1, "R6 overflow raised", int'(overflowFlag), 1);
    check(fillLevel == LVL_W'(DEPTH), "R6 level stays full", int'(fillLevel), DEPTH);

    // Random traffic, alternating heavy and light posting
    for (int n = 0; n < 4000; n++) begin
      int postPct;
      postPct = ((n / 400) % 2 == 0) ? 75 : 25;
      step(($urandom % 100) < postPct, CNT_W'($urandom), IDX_W'($urandom),
           ($urandom % 100) < 60, ($urandom % 100) < 40);
    end
    // Drain
    for (int n = 0; n < 200; n++) step(1'b0, '0, '0, 1'b1, 1'b1);
    step(1'b0, '0, '0, 1'b0, 1'b0);
    check(fillLevel == '0, "R2 drained", int'(fillLevel), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule